// File: doc/BRIEF.md
# Strap Capture and Pin Multiplexer for a Six-Line Port

The block configures a six-line multiplexed I/O port and captures the board's configuration straps. On the first clock edge after reset is released, it samples four strap inputs once. From these samples it latches three flags:

- a default wide-data flag for chip-select 0,
- a global three-state flag that silences every pad,
- an emulation request flag.

The flags hold until the next reset. They drive dedicated outputs and can be read through a read-only status register.

The block also holds four per-line control registers: pull-up enable, line select, GPIO direction and GPIO output data. For each line, the select register decides whether the pad follows the dedicated on-chip function or the general-purpose registers. A small strobe-based register bus gives software access to these registers. The bus has no back-pressure: a strobe is accepted in the cycle it is presented, and read data comes back exactly one cycle later with a valid flag. The pad input value is passed straight to the dedicated function and can be read through a pin register.

Top module: `pinmux_strap_ctrl`

## Requirements
- R1: On the first rising clock edge with `rst_n` high, the block samples the straps. Status register (address 5) bit 0 and `cs0_wide` then equal `strap_busw`. Bit 1 and `hiz_mode` equal the inverse of `strap_hiz_n`. Bits 7..3 read 0.
- R2: Once captured, the flags stay constant when the strap inputs change. They change only through a new reset.
- R3: `pad_oe` is all zero while `rst_n` is low, and until the capture edge. After capture, if the three-state flag is set, `pad_oe` stays all zero whatever the select, direction and function enables are.
- R4: Status bit 2 and `emu_mode` are 1 when either `strap_emu_irq_n` or `strap_emu_brk_n` was low at capture. They are 0 only when both were high.
- R5: The pull-up register is at address 0 and resets to 0x3D. `pad_pu` equals its bits 5..0, so line 1 has no pull-up after reset.
- R6: The select register is at address 1 and resets to 0x08, so only line 3 is a general-purpose line after reset. A select bit of 1 means the line is general-purpose.
- R7: When not in three-state mode, a line whose select bit is 1 drives `pad_oe` from direction register bit i (address 2, reset 0) and `pad_out` from data register bit i (address 3, reset 0). A line whose select bit is 0 drives `pad_oe`/`pad_out` from `fn_oe`/`fn_out`.
- R8: Bits 7..6 of every register ignore writes and read as 0. Addresses 6 and 7 read as 0, and writes to them have no effect.
- R9: A write (`bus_en`=1, `bus_we`=1) updates the register on the same clock edge. A read (`bus_en`=1, `bus_we`=0) sets `bus_rvalid` and presents `bus_rdata` after that edge, for one cycle.
- R10: The pin register (address 4) returns `pad_in` as sampled at the read edge. `fn_in` always equals `pad_in`.
- R11: The status and pin registers are read-only, so writes to addresses 4 and 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_busw | input | 1 | Data width strap (1 = wide) |
| strap_hiz_n | input | 1 | Three-state strap, active low |
| strap_emu_irq_n | input | 1 | Emulation interrupt strap, active low |
| strap_emu_brk_n | input | 1 | Emulation break strap, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| fn_out | input | 6 | Dedicated function output values |
| fn_oe | input | 6 | Dedicated function output enables |
| fn_in | output | 6 | Pad input to dedicated function |
| pad_in | input | 6 | Pad input values |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables |
| pad_pu | output | 6 | Pad pull-up enables |
| cs0_wide | output | 1 | Latched wide-data flag |
| hiz_mode | output | 1 | Latched three-state flag |
| emu_mode | output | 1 | Latched emulation flag |

## Verification
The pad outputs are combinational, so they are due in the same cycle as a change on their inputs. A register written at one edge affects the pads right after that edge. The bench drives every input at the falling edge and compares the pads at the next falling edge, which is after any register update. A read issued at falling edge k is answered after the following rising edge, so the bench samples `bus_rvalid` and `bus_rdata` at the next falling edge. Strap flags are due one edge after reset release: the bench checks the pads before that edge and the status right after it.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_PULL   = 3'd0,
    RA_SEL    = 3'd1,
    RA_DIR    = 3'd2,
    RA_DOUT   = 3'd3,
    RA_PIN    = 3'd4,
    RA_STATUS = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic emu;
    logic hiz;
    logic bus_wide;
  } strap_flags_t;
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import pinmux_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap_busw,
  input  logic         strap_hiz_n,
  input  logic         strap_emu_irq_n,
  input  logic         strap_emu_brk_n,
  output logic         captured,
  output strap_flags_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      flags    <= '0;
    end else if (!captured) begin
      captured       <= 1'b1;
      flags.bus_wide <= strap_busw;
      flags.hiz      <= ~strap_hiz_n;
      flags.emu      <= ~(strap_emu_irq_n & strap_emu_brk_n);
    end
  end

  AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> $stable(flags)); // R2
  AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(captured) |-> captured); // R2
endmodule

// File: rtl/port_regs.sv
module port_regs
  import pinmux_pkg::*;
#(
  parameter int PORT_W = 6,
  parameter int REG_W  = 8,
  parameter logic [PORT_W-1:0] PU_RST  = 6'h3D,
  parameter logic [PORT_W-1:0] SEL_RST = 6'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [PORT_W-1:0] pad_in,
  input  strap_flags_t      flags,
  output logic [PORT_W-1:0] pu_en,
  output logic [PORT_W-1:0] sel,
  output logic [PORT_W-1:0] dir,
  output logic [PORT_W-1:0] dout
);
  localparam int RSVD_W = REG_W - PORT_W;
  localparam int STAT_W = $bits(strap_flags_t);

  logic              wr_hit;
  logic              rd_hit;
  logic [PORT_W-1:0] wr_bits;
  logic [REG_W-1:0]  rd_mux;
  logic              unused_wdata;

  assign wr_hit       = bus_en & bus_we;
  assign rd_hit       = bus_en & ~bus_we;
  assign wr_bits      = bus_wdata[PORT_W-1:0];
  assign unused_wdata = ^bus_wdata[REG_W-1:PORT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_en <= PU_RST;
      sel   <= SEL_RST;
      dir   <= '0;
      dout  <= '0;
    end else if (wr_hit) begin
      case (bus_addr)
        RA_PULL: pu_en <= wr_bits;
        RA_SEL:  sel   <= wr_bits;
        RA_DIR:  dir   <= wr_bits;
        RA_DOUT: dout  <= wr_bits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      RA_PULL:   rd_mux = {{RSVD_W{1'b0}}, pu_en};
      RA_SEL:    rd_mux = {{RSVD_W{1'b0}}, sel};
      RA_DIR:    rd_mux = {{RSVD_W{1'b0}}, dir};
      RA_DOUT:   rd_mux = {{RSVD_W{1'b0}}, dout};
      RA_PIN:    rd_mux = {{RSVD_W{1'b0}}, pad_in};
      RA_STATUS: rd_mux = {{(REG_W-STAT_W){1'b0}}, flags};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_hit;
      bus_rdata  <= rd_hit ? rd_mux : '0;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> (bus_rdata[REG_W-1:PORT_W] == '0)); // R8
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> bus_rvalid); // R9
  AST_PULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && bus_addr == RA_PULL) |=> (pu_en == $past(wr_bits))); // R9
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && bus_addr == RA_SEL) |=> $stable(sel)); // R6
endmodule

// File: rtl/pad_mux.sv
module pad_mux #(
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet,
  input  logic [PORT_W-1:0] sel,
  input  logic [PORT_W-1:0] dir,
  input  logic [PORT_W-1:0] dout,
  input  logic [PORT_W-1:0] fn_out,
  input  logic [PORT_W-1:0] fn_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_line
    logic line_oe;
    logic line_out;

    always_comb begin
      if (sel[i]) begin
        line_oe  = dir[i];
        line_out = dout[i];
      end else begin
        line_oe  = fn_oe[i];
        line_out = fn_out[i];
      end
    end

    assign pad_oe[i]  = line_oe & ~quiet;
    assign pad_out[i] = line_out;

    AST_GPIO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!quiet && sel[i]) |-> (pad_oe[i] == dir[i] && pad_out[i] == dout[i])); // R7
    AST_FUNC_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!quiet && !sel[i]) |-> (pad_oe[i] == fn_oe[i] && pad_out[i] == fn_out[i])); // R7
  end

  AST_QUIET_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (pad_oe == '0)); // R3
endmodule

// File: rtl/pinmux_strap_ctrl.sv
module pinmux_strap_ctrl
  import pinmux_pkg::*;
#(
  parameter int PORT_W = 6,
  parameter int REG_W  = 8,
  parameter logic [PORT_W-1:0] PU_RST  = 6'h3D,
  parameter logic [PORT_W-1:0] SEL_RST = 6'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_busw,
  input  logic              strap_hiz_n,
  input  logic              strap_emu_irq_n,
  input  logic              strap_emu_brk_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [PORT_W-1:0] fn_out,
  input  logic [PORT_W-1:0] fn_oe,
  output logic [PORT_W-1:0] fn_in,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_pu,
  output logic              cs0_wide,
  output logic              hiz_mode,
  output logic              emu_mode
);
  logic              captured;
  strap_flags_t      flags;
  logic [PORT_W-1:0] sel;
  logic [PORT_W-1:0] dir;
  logic [PORT_W-1:0] dout;
  logic              quiet;

  strap_latch u_strap (
    .clk             (clk),
    .rst_n           (rst_n),
    .strap_busw      (strap_busw),
    .strap_hiz_n     (strap_hiz_n),
    .strap_emu_irq_n (strap_emu_irq_n),
    .strap_emu_brk_n (strap_emu_brk_n),
    .captured        (captured),
    .flags           (flags)
  );

  port_regs #(
    .PORT_W  (PORT_W),
    .REG_W   (REG_W),
    .PU_RST  (PU_RST),
    .SEL_RST (SEL_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pad_in     (pad_in),
    .flags      (flags),
    .pu_en      (pad_pu),
    .sel        (sel),
    .dir        (dir),
    .dout       (dout)
  );

  assign quiet = ~captured | flags.hiz;

  pad_mux #(.PORT_W(PORT_W)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .quiet   (quiet),
    .sel     (sel),
    .dir     (dir),
    .dout    (dout),
    .fn_out  (fn_out),
    .fn_oe   (fn_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  assign fn_in    = pad_in;
  assign cs0_wide = flags.bus_wide;
  assign hiz_mode = flags.hiz;
  assign emu_mode = flags.emu;

  AST_PRECAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> (pad_oe == '0)); // R3
  AST_EMU_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> $stable(emu_mode)); // R4
  AST_FN_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fn_in == pad_in); // R10
endmodule

// File: tb/test_pinmux_strap_ctrl.sv
`timescale 1ns/1ps
module test_pinmux_strap_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_busw = 1'b1, strap_hiz_n = 1'b1, strap_emu_irq_n = 1'b1, strap_emu_brk_n = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic [5:0] fn_out = '0, fn_oe = '0, pad_in = '0;
  logic [5:0] fn_in, pad_out, pad_oe, pad_pu;
  logic       cs0_wide, hiz_mode, emu_mode;

  int errors = 0;
  int checks = 0;

  logic [5:0] m_pu, m_sel, m_dir, m_dout;
  logic [2:0] m_stat;

  always #2.5 clk = ~clk;

  pinmux_strap_ctrl i_pinmux_strap_ctrl (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {2'b00, m_pu};
      3'd1: return {2'b00, m_sel};
      3'd2: return {2'b00, m_dir};
      3'd3: return {2'b00, m_dout};
      3'd4: return {2'b00, pad_in};
      3'd5: return {5'b0, m_stat};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [5:0] exp_oe();
    if (m_stat[1]) return 6'h00;
    return (m_sel & m_dir) | (~m_sel & fn_oe);
  endfunction

  function automatic logic [5:0] exp_out();
    return (m_sel & m_dout) | (~m_sel & fn_out);
  endfunction

  task automatic do_reset(input logic bw, input logic hz, input logic iq, input logic bk);
    @(negedge clk);
    rst_n = 1'b0;
    strap_busw = bw; strap_hiz_n = hz; strap_emu_irq_n = iq; strap_emu_brk_n = bk;
    fn_oe = 6'h3F;
    repeat (2) @(negedge clk);
    check("R3 oe during reset", {2'b0, pad_oe}, 8'h00);
    rst_n = 1'b1;
    #1 check("R3 oe before capture", {2'b0, pad_oe}, 8'h00);
    @(negedge clk);
    m_pu = 6'h3D; m_sel = 6'h08; m_dir = '0; m_dout = '0;
    m_stat = {~(iq & bk), ~hz, bw};
    check("R1 cs0_wide", {7'b0, cs0_wide}, {7'b0, bw});
    check("R1 hiz_mode", {7'b0, hiz_mode}, {7'b0, ~hz});
    check("R4 emu_mode", {7'b0, emu_mode}, {7'b0, ~(iq & bk)});
    check("R5 pad_pu reset", {2'b0, pad_pu}, 8'h3D);
    check("R3/R7 oe after capture", {2'b0, pad_oe}, {2'b0, exp_oe()});
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    case (a)
      3'd0: m_pu = d[5:0];
      3'd1: m_sel = d[5:0];
      3'd2: m_dir = d[5:0];
      3'd3: m_dout = d[5:0];
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [2:0] a, input string req);
    logic [7:0] e;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    e = exp_read(a);
    @(negedge clk);
    bus_en = 1'b0;
    check({req, " rvalid"}, {7'b0, bus_rvalid}, 8'h01);
    check(req, bus_rdata, e);
  endtask

  task automatic check_pads(input string req);
    #1;
    check({req, " pad_oe"}, {2'b0, pad_oe}, {2'b0, exp_oe()});
    check({req, " pad_out"}, {2'b0, pad_out}, {2'b0, exp_out()});
    check({req, " pad_pu"}, {2'b0, pad_pu}, {2'b0, m_pu});
    check("R10 fn_in", {2'b0, fn_in}, {2'b0, pad_in});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'hC0FFEE);
    // Normal straps, wide bus
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    bus_read(3'd0, "R5 pull reset read");
    bus_read(3'd1, "R6 sel reset read");
    bus_read(3'd2, "R7 dir reset read");
    bus_read(3'd5, "R1 status read");
    // Reserved bits and unmapped space
    bus_write(3'd0, 8'hC2);
    bus_read(3'd0, "R8 reserved bits");
    bus_write(3'd6, 8'hFF);
    bus_read(3'd6, "R8 unmapped read");
    bus_write(3'd5, 8'hFF);
    bus_read(3'd5, "R11 status write ignored");
    bus_write(3'd4, 8'h3F);
    pad_in = 6'h15;
    bus_read(3'd4, "R10 pin read");
    bus_read(3'd0, "R11 regs unchanged");
    // Directed routing corner: all GPIO out, then all function
    bus_write(3'd2, 8'h3F); bus_write(3'd3, 8'h2A); bus_write(3'd1, 8'h3F);
    fn_oe = 6'h00; fn_out = 6'h15;
    check_pads("R7 all gpio");
    bus_write(3'd1, 8'h00);
    check_pads("R7 all function");
    // Random traffic
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      fn_oe = 6'($urandom); fn_out = 6'($urandom); pad_in = 6'($urandom);
      if ($urandom_range(0, 1) == 0) bus_write(a, 8'($urandom));
      else bus_read(a, "R9 random read");
      check_pads("R7 random");
    end
    // Straps change after capture
    strap_busw = 1'b0; strap_hiz_n = 1'b0; strap_emu_irq_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(3'd5, "R2 status holds");
    check("R2 hiz holds", {7'b0, hiz_mode}, 8'h00);
    // Three-state strap with emulation interrupt, narrow bus
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    bus_write(3'd1, 8'h3F); bus_write(3'd2, 8'h3F);
    fn_oe = 6'h3F;
    check_pads("R3 hiz override");
    bus_read(3'd5, "R1 R4 status hiz emu");
    for (int i = 0; i < 50; i++) begin
      fn_oe = 6'($urandom);
      if ($urandom_range(0, 1) == 0) bus_write(3'($urandom_range(0, 3)), 8'($urandom));
      else @(negedge clk);
      check_pads("R3 random hiz");
    end
    // Break strap alone requests emulation
    do_reset(1'b1, 1'b1, 1'b1, 1'b0);
    bus_read(3'd5, "R4 break only");
    check_pads("R7 after third reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule